// File: doc/BRIEF.md
# Infrared Receive Edge Timer

This block measures the timing of an infrared receive line. The raw pin passes through a synchronizer, and transitions chosen by an edge-select field count as qualified events. A 16-bit interval timer starts from zero at the first qualified event after the receiver is started. On each later event the timer value and the new line level are latched, and the timer may be cleared for the next interval. The timer either steps on every module clock for fine resolution, or once per programmable carrier period. The carrier period is (high count + 1) + (low count + 1) module clocks.

A second mode helps when learning a remote-control code. In this mode the capture register counts qualified edges instead of holding times. The event flag then marks the start of a space: it is set when two full carrier periods pass with no qualified edge. Event and overflow flags stay set until their clear strobes, and each flag can request an interrupt through its own enable.

Top module: `irRxCapture`

## Requirements
- R1: The receiver runs only when cfgRun=1 and cfgTxMode=0. Otherwise pin activity leaves capVal, rxLevel and the flags unchanged, and timerVal reads 0.
- R2: cfgEdgeSel selects the qualified edges: 2'b00 falling only, 2'b01 rising only, 2'b10 and 2'b11 both edges. Transitions that are not selected have no effect.
- R3: With cfgFine=1 and cfgReload=1, two qualified pin transitions N clocks apart load capVal with N-1 and set evtFlag.
- R4: With cfgFine=0, the timer steps once per carrier period of P=(cfgCarHigh+1)+(cfgCarLow+1) clocks. The carrier phase restarts at each qualified edge, so an interval of N clocks captures floor((N-1)/P).
- R5: On every capture, and on every counted edge in burst mode, rxLevel takes the synchronized line level: 1 after a rising edge, 0 after a falling edge.
- R6: With cfgReload=0, a capture does not clear the timer. Two fine-mode intervals of N clocks each capture N-1 and then 2N-1.
- R7: If the armed timer wraps from all ones to zero without a qualified event in that cycle, ovfFlag is set.
- R8: When cfgBurst goes from 0 to 1, capVal is loaded with 1. While cfgBurst=1, interval capture is suppressed and each qualified edge adds 1 to capVal.
- R9: In burst mode, once armed, evtFlag is set exactly 2P clocks after the last qualified edge. It is set once per silent stretch.
- R10: evtFlag and ovfFlag stay set until evtClr or ovfClr, respectively, is high at a clock edge. A set in the same cycle wins over the clear.
- R11: irq = (evtFlag AND cfgEvtIe) OR (ovfFlag AND cfgOvfIe).
- R12: After reset, timerVal, capVal, rxLevel, evtFlag, ovfFlag and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgRun | input | 1 | Receiver enable |
| cfgTxMode | input | 1 | 1 selects transmit, which stops the receiver |
| cfgEdgeSel | input | 2 | Qualified edge selection |
| cfgFine | input | 1 | 1: timer steps each clock; 0: each carrier period |
| cfgReload | input | 1 | Clear the timer on each capture |
| cfgBurst | input | 1 | Burst edge-count mode |
| cfgCarHigh | input | 8 | Carrier high phase length minus one |
| cfgCarLow | input | 8 | Carrier low phase length minus one |
| cfgEvtIe | input | 1 | Event interrupt enable |
| cfgOvfIe | input | 1 | Overflow interrupt enable |
| evtClr | input | 1 | One-cycle clear of evtFlag |
| ovfClr | input | 1 | One-cycle clear of ovfFlag |
| rxPin | input | 1 | Raw asynchronous receive line |
| timerVal | output | 16 | Current interval timer |
| capVal | output | 16 | Captured interval or edge count |
| rxLevel | output | 1 | Line level latched at the last event |
| evtFlag | output | 1 | Capture done, or carrier absent in burst mode |
| ovfFlag | output | 1 | Timer wrapped |
| irq | output | 1 | Interrupt request |

## Verification
A wrong arming state or wrong carrier phase shows up at the next capture. The error appears as capVal off by a whole interval, or off by one carrier period, three clocks after the pin moves. A silence counter that is off by one shifts the evtFlag rise by a full carrier period, and that rise is checked on the exact clock. A missed or doubled burst-mode load or increment leaves the edge count wrong by one as soon as the burst settles. A stuck flag shows on irq once its enable is raised.

// File: rtl/irRxPkg.sv
package irRxPkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_BOTH_ALT = 2'b11
  } edgeSel_e;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic hold;        // receiver stopped: timer forced to zero
    logic arm;         // first qualified edge: timer starts from zero
    logic capture;     // interval capture event
    logic countEdge;   // burst mode edge count
    logic latchLevel;  // take the synchronized line level
    logic loadOne;     // burst mode entry preload
    logic advance;     // timer step
    logic reload;      // clear the timer on an event
    logic silence;     // burst mode carrier absence
  } ctlStrobe_t;

endpackage

// File: rtl/irRxSync.sv
module irRxSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxPin,
  output logic lineNow,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] chain;
  logic linePrev;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= rxPin;
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rxPin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) linePrev <= 1'b0;
    else       linePrev <= chain[SYNC_STAGES-1];

  assign lineNow = chain[SYNC_STAGES-1];
  assign rise    = lineNow & ~linePrev;
  assign fall    = ~lineNow & linePrev;
endmodule

// File: rtl/irRxCtrl.sv
module irRxCtrl
  import irRxPkg::*;
#(
  parameter int CAR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [1:0]       edgeSel,
  input  logic             fine,
  input  logic             reload,
  input  logic             burst,
  input  logic [CAR_W-1:0] carHigh,
  input  logic [CAR_W-1:0] carLow,
  input  logic             rise,
  input  logic             fall,
  output ctlStrobe_t       strobe
);
  localparam int PW = CAR_W + 2;

  logic          armed;
  logic          burstPrev;
  logic [PW-1:0] carCnt;
  logic [PW-1:0] period;
  logic [1:0]    silCnt;
  logic          qual;
  logic          carTick;

  always_comb begin
    unique case (edgeSel_e'(edgeSel))
      EDGE_FALL: qual = fall;
      EDGE_RISE: qual = rise;
      default:   qual = rise | fall;
    endcase
  end

  assign period  = PW'(carHigh) + PW'(carLow) + PW'(2);
  assign carTick = run && (carCnt == period - PW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      burstPrev <= 1'b0;
      carCnt    <= '0;
      silCnt    <= '0;
    end else begin
      burstPrev <= burst;
      if (!run)      armed <= 1'b0;
      else if (qual) armed <= 1'b1;

      if (!run || qual || carTick) carCnt <= '0;
      else                         carCnt <= carCnt + PW'(1);

      if (!run || qual)                    silCnt <= '0;
      else if (carTick && silCnt != 2'd2)  silCnt <= silCnt + 2'd1;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.hold       = !run;
    strobe.arm        = run && qual && !armed;
    strobe.capture    = run && qual && armed && !burst;
    strobe.countEdge  = run && qual && burst;
    strobe.latchLevel = run && qual && (armed || burst);
    strobe.loadOne    = burst && !burstPrev;
    strobe.advance    = run && armed && (fine || carTick);
    strobe.reload     = reload;
    strobe.silence    = run && burst && armed && !qual && carTick && (silCnt == 2'd1);
  end
endmodule

// File: rtl/irRxDatapath.sv
module irRxDatapath
  import irRxPkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic               lineNow,
  input  logic               evtClr,
  input  logic               ovfClr,
  output logic [TIMER_W-1:0] timerVal,
  output logic [TIMER_W-1:0] capVal,
  output logic               rxLevel,
  output logic               evtFlag,
  output logic               ovfFlag
);
  localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

  logic event_;
  logic wrap;
  logic evtSet;

  assign event_ = strobe.capture | strobe.countEdge;
  assign wrap   = strobe.advance && (&timerVal) && !event_;
  assign evtSet = strobe.capture | strobe.silence;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerVal <= '0;
      capVal   <= '0;
      rxLevel  <= 1'b0;
      evtFlag  <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (strobe.hold || strobe.arm)       timerVal <= '0;
      else if (event_ && strobe.reload)    timerVal <= '0;
      else if (strobe.advance)             timerVal <= timerVal + ONE;

      if (strobe.loadOne)                  capVal <= ONE;
      else if (strobe.countEdge)           capVal <= capVal + ONE;
      else if (strobe.capture)             capVal <= timerVal;

      if (strobe.latchLevel)               rxLevel <= lineNow;

      if (evtSet)                          evtFlag <= 1'b1;
      else if (evtClr)                     evtFlag <= 1'b0;

      if (wrap)                            ovfFlag <= 1'b1;
      else if (ovfClr)                     ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/irRxCapture.sv
module irRxCapture
  import irRxPkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int CAR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgRun,
  input  logic               cfgTxMode,
  input  logic [1:0]         cfgEdgeSel,
  input  logic               cfgFine,
  input  logic               cfgReload,
  input  logic               cfgBurst,
  input  logic [CAR_W-1:0]   cfgCarHigh,
  input  logic [CAR_W-1:0]   cfgCarLow,
  input  logic               cfgEvtIe,
  input  logic               cfgOvfIe,
  input  logic               evtClr,
  input  logic               ovfClr,
  input  logic               rxPin,
  output logic [TIMER_W-1:0] timerVal,
  output logic [TIMER_W-1:0] capVal,
  output logic               rxLevel,
  output logic               evtFlag,
  output logic               ovfFlag,
  output logic               irq
);
  logic       lineNow;
  logic       rise;
  logic       fall;
  logic       run;
  ctlStrobe_t strobe;

  assign run = cfgRun & ~cfgTxMode;

  irRxSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .rxPin(rxPin),
    .lineNow(lineNow), .rise(rise), .fall(fall)
  );

  irRxCtrl #(.CAR_W(CAR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .run(run), .edgeSel(cfgEdgeSel),
    .fine(cfgFine), .reload(cfgReload), .burst(cfgBurst),
    .carHigh(cfgCarHigh), .carLow(cfgCarLow),
    .rise(rise), .fall(fall), .strobe(strobe)
  );

  irRxDatapath #(.TIMER_W(TIMER_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineNow(lineNow),
    .evtClr(evtClr), .ovfClr(ovfClr),
    .timerVal(timerVal), .capVal(capVal), .rxLevel(rxLevel),
    .evtFlag(evtFlag), .ovfFlag(ovfFlag)
  );

  assign irq = (evtFlag & cfgEvtIe) | (ovfFlag & cfgOvfIe);
endmodule

// File: rtl/irRxCaptureChk.sv
module irRxCaptureChk #(
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgRun,
  input logic               cfgTxMode,
  input logic               cfgBurst,
  input logic               cfgEvtIe,
  input logic               cfgOvfIe,
  input logic               evtClr,
  input logic               ovfClr,
  input logic [TIMER_W-1:0] timerVal,
  input logic [TIMER_W-1:0] capVal,
  input logic               evtFlag,
  input logic               ovfFlag,
  input logic               irq
);
  localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

  AST_IDLE_CAP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!(cfgRun && !cfgTxMode) && !cfgBurst) |=> $stable(capVal)); // R1
  AST_IDLE_TIMER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgRun && !cfgTxMode) |=> (timerVal == '0)); // R1
  AST_OVF_FROM_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(timerVal) == {TIMER_W{1'b1}})); // R7
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    cfgBurst |=> (capVal == $past(capVal) || capVal == $past(capVal) + ONE || capVal == ONE)); // R8
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (evtFlag && !evtClr) |=> evtFlag); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEvtIe && !cfgOvfIe) |-> !irq); // R11
endmodule

bind irRxCapture irRxCaptureChk #(.TIMER_W(TIMER_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgRun(cfgRun), .cfgTxMode(cfgTxMode),
  .cfgBurst(cfgBurst), .cfgEvtIe(cfgEvtIe), .cfgOvfIe(cfgOvfIe),
  .evtClr(evtClr), .ovfClr(ovfClr), .timerVal(timerVal), .capVal(capVal),
  .evtFlag(evtFlag), .ovfFlag(ovfFlag), .irq(irq)
);

// File: tb/tb_irRxCapture.sv
`timescale 1ns/1ps
module tb_irRxCapture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgRun = 1'b0, cfgTxMode = 1'b0, cfgFine = 1'b1, cfgReload = 1'b1, cfgBurst = 1'b0;
  logic [1:0]  cfgEdgeSel = 2'b10;
  logic [7:0]  cfgCarHigh = 8'd2, cfgCarLow = 8'd1;
  logic        cfgEvtIe = 1'b0, cfgOvfIe = 1'b0;
  logic        evtClr = 1'b0, ovfClr = 1'b0;
  logic        rxPin = 1'b0;
  logic [15:0] timerVal, capVal;
  logic        rxLevel, evtFlag, ovfFlag, irq;

  int nChecks = 0;
  int nFail = 0;
  bit monOn = 1'b0;
  logic [15:0] capQ[$];
  logic        lvlQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  irRxCapture dut (
    .clk(clk), .rstN(rstN), .cfgRun(cfgRun), .cfgTxMode(cfgTxMode),
    .cfgEdgeSel(cfgEdgeSel), .cfgFine(cfgFine), .cfgReload(cfgReload),
    .cfgBurst(cfgBurst), .cfgCarHigh(cfgCarHigh), .cfgCarLow(cfgCarLow),
    .cfgEvtIe(cfgEvtIe), .cfgOvfIe(cfgOvfIe), .evtClr(evtClr), .ovfClr(ovfClr),
    .rxPin(rxPin), .timerVal(timerVal), .capVal(capVal), .rxLevel(rxLevel),
    .evtFlag(evtFlag), .ovfFlag(ovfFlag), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expectCap(input logic [15:0] c, input logic l, input string tag);
    capQ.push_back(c);
    lvlQ.push_back(l);
    tagQ.push_back(tag);
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pinAfter(input int n, input logic v);
    clocks(n);
    rxPin = v;
  endtask

  task automatic restart(input logic pinLevel);
    @(negedge clk);
    cfgRun = 1'b0;
    rxPin = pinLevel;
    clocks(5);
    cfgRun = 1'b1;
    clocks(1);
  endtask

  task automatic drain(input string tag);
    clocks(8);
    check(capQ.size() == 0, tag, capQ.size(), 0);
  endtask

  // Monitor: compares each capture against the scoreboard, then clears the flag
  initial begin
    forever begin
      @(negedge clk);
      if (monOn && evtFlag) begin
        if (capQ.size() == 0) begin
          check(1'b0, "R3", capVal, 16'hxxxx);
        end else begin
          logic [15:0] c;
          logic l;
          string t;
          c = capQ.pop_front();
          l = lvlQ.pop_front();
          t = tagQ.pop_front();
          check(capVal == c, t, capVal, c);
          check(rxLevel == l, "R5", rxLevel, l);
        end
        evtClr = 1'b1;
        @(negedge clk);
        evtClr = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    clocks(3);
    rstN = 1'b1;
    clocks(2);
    // R12 reset state
    check(timerVal == 0, "R12", timerVal, 0);
    check(capVal == 0, "R12", capVal, 0);
    check({rxLevel, evtFlag, ovfFlag, irq} == 4'b0, "R12", {rxLevel, evtFlag, ovfFlag, irq}, 0);

    // R1 stopped: disabled, then transmit mode
    pinAfter(1, 1'b1); pinAfter(6, 1'b0); pinAfter(6, 1'b1); clocks(6);
    check(capVal == 0 && timerVal == 0, "R1", {capVal, timerVal}, 0);
    check(evtFlag == 0 && rxLevel == 0, "R1", {evtFlag, rxLevel}, 0);
    cfgTxMode = 1'b1; cfgRun = 1'b1;
    pinAfter(2, 1'b0); pinAfter(7, 1'b1); pinAfter(7, 1'b0); clocks(7);
    check(capVal == 0 && timerVal == 0, "R1", {capVal, timerVal}, 0);
    check(evtFlag == 0 && rxLevel == 0, "R1", {evtFlag, rxLevel}, 0);
    cfgTxMode = 1'b0;

    // R3 fine intervals, both edges, reload on
    monOn = 1'b1;
    cfgEdgeSel = 2'b10;
    restart(1'b0);
    rxPin = 1'b1;
    expectCap(16'd19, 1'b0, "R3"); pinAfter(20, 1'b0);
    expectCap(16'd36, 1'b1, "R3"); pinAfter(37, 1'b1);
    drain("R3");

    // R2 rising only: the falling edge in between is ignored
    cfgEdgeSel = 2'b01;
    restart(1'b0);
    rxPin = 1'b1;
    pinAfter(10, 1'b0);
    expectCap(16'd24, 1'b1, "R2"); pinAfter(15, 1'b1);
    drain("R2");
    // R2 falling only
    cfgEdgeSel = 2'b00;
    restart(1'b1);
    rxPin = 1'b0;
    pinAfter(8, 1'b1);
    expectCap(16'd16, 1'b0, "R2"); pinAfter(9, 1'b0);
    drain("R2");
    // R2 encoding 11 also takes both edges
    cfgEdgeSel = 2'b11;
    restart(1'b0);
    rxPin = 1'b1;
    expectCap(16'd13, 1'b0, "R2"); pinAfter(14, 1'b0);
    drain("R2");

    // R6 no reload: timer keeps running through captures
    cfgEdgeSel = 2'b10; cfgReload = 1'b0;
    restart(1'b0);
    rxPin = 1'b1;
    expectCap(16'd11, 1'b0, "R6"); pinAfter(12, 1'b0);
    expectCap(16'd23, 1'b1, "R6"); pinAfter(12, 1'b1);
    drain("R6");
    cfgReload = 1'b1;

    // R4 carrier ticks, P = 3 + 2 = 5
    cfgFine = 1'b0;
    restart(1'b0);
    rxPin = 1'b1;
    expectCap(16'd4, 1'b0, "R4"); pinAfter(23, 1'b0);
    expectCap(16'd6, 1'b1, "R4"); pinAfter(31, 1'b1);
    drain("R4");

    // R7 overflow in fine mode, R11 masking, R10 clear
    cfgFine = 1'b1;
    restart(1'b0);
    rxPin = 1'b1;
    clocks(65530);
    check(ovfFlag == 1'b0, "R7", ovfFlag, 0);
    clocks(15);
    check(ovfFlag == 1'b1, "R7", ovfFlag, 1);
    check(irq == 1'b0, "R11", irq, 0);
    cfgOvfIe = 1'b1;
    clocks(1);
    check(irq == 1'b1, "R11", irq, 1);
    clocks(3);
    check(ovfFlag == 1'b1, "R10", ovfFlag, 1);
    ovfClr = 1'b1;
    clocks(1);
    ovfClr = 1'b0;
    check(ovfFlag == 1'b0 && irq == 1'b0, "R10", {ovfFlag, irq}, 0);
    cfgOvfIe = 1'b0;

    // R8 burst entry preload while stopped
    monOn = 1'b0;
    @(negedge clk); cfgRun = 1'b0;
    clocks(2);
    cfgBurst = 1'b1;
    clocks(1);
    check(capVal == 16'd1, "R8", capVal, 1);
    cfgFine = 1'b0;
    restart(1'b0);
    check(capVal == 16'd1, "R8", capVal, 1);
    rxPin = 1'b1;
    pinAfter(2, 1'b0); pinAfter(2, 1'b1); pinAfter(2, 1'b0);
    clocks(4);
    check(capVal == 16'd5, "R8", capVal, 5);
    check(rxLevel == 1'b0, "R5", rxLevel, 0);
    // R9 silence flag at exactly 2P = 10 clocks after the last edge
    check(evtFlag == 1'b0, "R9", evtFlag, 0);
    clocks(8);
    check(evtFlag == 1'b0, "R9", evtFlag, 0);
    clocks(1);
    check(evtFlag == 1'b1, "R9", evtFlag, 1);
    cfgEvtIe = 1'b1;
    clocks(1);
    check(irq == 1'b1, "R11", irq, 1);
    evtClr = 1'b1;
    clocks(1);
    evtClr = 1'b0;
    check(evtFlag == 1'b0 && irq == 1'b0, "R10", {evtFlag, irq}, 0);
    clocks(25);
    check(evtFlag == 1'b0, "R9", evtFlag, 0);
    check(capVal == 16'd5, "R8", capVal, 5);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule